// File: doc/BRIEF.md
# Debug halt source arbiter

This block sits next to a simple processor pipeline model. It decides what happens to each debug halt or fault source. Each clock cycle it looks at four sources:

- a fault raised while an exception is already being processed,
- a hardware breakpoint trigger,
- a decoded halt opcode,
- a background-entry command strobe from the debug port.

For each one it chooses an outcome: stop the core at once, record a halt to be taken at the next instruction boundary, raise an exception, or ask for a system reset. The choice depends on the privilege level, the debug-enable bit, the flash security state, the stopped state, the user-halt-enable bit and two reset-disable bits.

The block keeps the halted state itself. A GO strobe from the debug port releases it. Every output is registered, so each decision appears on the outputs one clock after the inputs that caused it. When one decision is taken in a cycle, the others from that cycle are suppressed by a fixed priority. The pipeline uses the halt cause code to pick the resume point. A halt taken out of the stopped state resumes after the stop instruction. A halt-opcode halt resumes after the halt opcode.

Top module: `halt_src_arb`

## Requirements
- R1: After reset, every output is 0. This includes `halted`, `pend_halt`, `exc_kind` and `reset_req`.
- R2: Fault-on-fault (`fault_in_exc`):
  - With `dbg_en`=1 it enters the halted state immediately, with `halt_cause`=0.
  - With `dbg_en`=0 it raises `reset_req`.
- R3: A halt opcode with `dbg_en`=1 enters the halted state immediately, with `halt_cause`=1. This applies when either `sup_mode`=1 or `user_halt_en`=1.
- R4: A halt opcode with `dbg_en`=1, `sup_mode`=0 and `user_halt_en`=0 is a privilege violation.
  - With `rst_dis_priv`=0 it raises `reset_req`.
  - With `rst_dis_priv`=1 it raises `exc_kind`=1.
- R5: A halt opcode with `dbg_en`=0 is an illegal instruction.
  - With `rst_dis_illegal`=0 it raises `reset_req`.
  - With `rst_dis_illegal`=1 it raises `exc_kind`=2.
- R6: A background command with `dbg_en`=0 or `flash_secure`=1 raises `cmd_err`. It has no other effect.
- R7: The pending halt:
  - A breakpoint trigger sets `pend_halt`.
  - An accepted background command while `cpu_stopped`=0 also sets `pend_halt`.
  - A pending halt is taken at the next cycle with `insn_bound`=1 and gives `halt_cause`=2.
  - `pend_halt` clears when the halted state is entered.
- R8: An accepted background command while `cpu_stopped`=1 enters the halted state immediately, with `halt_cause`=3.
- R9: The halted state:
  - `go_cmd` releases the halted state only while `halted`=1. At any other time it is ignored.
  - While halted, the fault, halt-opcode and breakpoint inputs are ignored.
- R10: When sources compete in one cycle, the priority from highest to lowest is:
  1. reset request,
  2. immediate halt,
  3. exception,
  4. taking a pending halt.

  A lower-priority outcome is suppressed, and a pending halt stays recorded.
- R11: Each outcome appears on the outputs exactly one clock after its inputs. `halt_enter` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_in_exc | input | 1 | Fault raised during exception processing |
| bkpt_trig | input | 1 | Hardware breakpoint trigger |
| halt_op | input | 1 | Halt opcode being executed |
| bgnd_cmd | input | 1 | Background-entry command strobe |
| go_cmd | input | 1 | Restart command strobe |
| insn_bound | input | 1 | Instruction boundary sample point |
| sup_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| dbg_en | input | 1 | Debug enabled |
| flash_secure | input | 1 | Flash secured |
| cpu_stopped | input | 1 | Core is in the stopped low-power state |
| user_halt_en | input | 1 | User-mode halt permitted |
| rst_dis_priv | input | 1 | 1 = privilege fault gives an exception, not a reset |
| rst_dis_illegal | input | 1 | 1 = illegal opcode gives an exception, not a reset |
| halted | output | 1 | Core is in the halted state |
| halt_enter | output | 1 | One-cycle pulse on entry to the halted state |
| halt_cause | output | 2 | Cause of the last halt: 0 fault-on-fault, 1 halt opcode, 2 pending, 3 from stopped |
| pend_halt | output | 1 | A halt is pending for the next boundary |
| exc_kind | output | 2 | Exception pulse: 0 none, 1 privilege, 2 illegal |
| reset_req | output | 1 | System reset request pulse |
| cmd_err | output | 1 | Illegal-command response pulse |

## Verification
The hardest situation to reach is a pending halt arriving at an instruction boundary in the same cycle as a higher-priority exception or reset. Reaching it needs a breakpoint or background command, then a gap without a boundary, then a boundary that coincides with a user-mode halt opcode under the right reset-disable setting. Directed sequences build this collision on purpose. Long random runs then use a low boundary rate and frequent halt opcodes, so the collision recurs under many mode combinations. Each random run is compared against a bench model derived from the requirements.

// File: rtl/halt_src_pkg.sv
package halt_src_pkg;
    localparam int EXC_W   = 2;
    localparam int CAUSE_W = 2;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE = 2'd0,
        EXC_PRIV = 2'd1,
        EXC_ILL  = 2'd2
    } exc_kind_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_FOF    = 2'd0,
        CAUSE_HALTOP = 2'd1,
        CAUSE_PEND   = 2'd2,
        CAUSE_STOPBG = 2'd3
    } cause_e;

    typedef struct packed {
        logic      rst_req;
        logic      imm_halt;
        cause_e    imm_cause;
        exc_kind_e exc;
        logic      pend_set;
        logic      cmd_err;
    } src_req_t;

    typedef struct packed {
        logic      halted;
        logic      enter;
        logic      pend;
        cause_e    cause;
        exc_kind_e exc;
        logic      reset_req;
        logic      cmd_err;
    } arb_state_t;
endpackage

// File: rtl/halt_src_decode.sv
module halt_src_decode
    import halt_src_pkg::*;
(
    input  logic     halted_q,
    input  logic     fault_in_exc,
    input  logic     bkpt_trig,
    input  logic     halt_op,
    input  logic     bgnd_cmd,
    input  logic     sup_mode,
    input  logic     dbg_en,
    input  logic     flash_secure,
    input  logic     cpu_stopped,
    input  logic     user_halt_en,
    input  logic     rst_dis_priv,
    input  logic     rst_dis_illegal,
    output src_req_t req
);
    logic live;
    logic fof, hop, bk, bg_ok;
    logic halt_ok, priv_flt, ill_flt, stop_bg;

    always_comb begin
        // instruction-side sources only matter while the core executes
        live     = !halted_q;
        fof      = live && fault_in_exc;
        hop      = live && halt_op;
        bk       = live && bkpt_trig;
        bg_ok    = bgnd_cmd && dbg_en && !flash_secure;
        halt_ok  = hop && dbg_en && (sup_mode || user_halt_en);
        priv_flt = hop && dbg_en && !sup_mode && !user_halt_en;
        ill_flt  = hop && !dbg_en;
        stop_bg  = live && bg_ok && cpu_stopped;

        req.rst_req  = (fof && !dbg_en)
                     || (priv_flt && !rst_dis_priv)
                     || (ill_flt && !rst_dis_illegal);
        req.imm_halt = (fof && dbg_en) || halt_ok || stop_bg;

        if (fof && dbg_en)      req.imm_cause = CAUSE_FOF;
        else if (halt_ok)       req.imm_cause = CAUSE_HALTOP;
        else                    req.imm_cause = CAUSE_STOPBG;

        if (priv_flt && rst_dis_priv)        req.exc = EXC_PRIV;
        else if (ill_flt && rst_dis_illegal) req.exc = EXC_ILL;
        else                                 req.exc = EXC_NONE;

        req.pend_set = bk || (live && bg_ok && !cpu_stopped);
        req.cmd_err  = bgnd_cmd && (!dbg_en || flash_secure);
    end
endmodule

// File: rtl/halt_src_core.sv
module halt_src_core
    import halt_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  src_req_t   req,
    input  logic       go_cmd,
    input  logic       insn_bound,
    output arb_state_t st_q
);
    arb_state_t st_d;
    logic       take_pend;

    always_comb begin
        st_d         = st_q;
        st_d.enter   = 1'b0;
        st_d.exc     = EXC_NONE;
        st_d.reset_req = req.rst_req;
        st_d.cmd_err = req.cmd_err;

        // lowest priority: a recorded halt taken at a boundary
        take_pend = st_q.pend && insn_bound && (req.exc == EXC_NONE);

        if (!req.rst_req) begin
            if (req.imm_halt) begin
                st_d.enter = !st_q.halted;
                st_d.cause = req.imm_cause;
            end else if (req.exc != EXC_NONE) begin
                st_d.exc = req.exc;
            end else if (take_pend && !st_q.halted) begin
                st_d.enter = 1'b1;
                st_d.cause = CAUSE_PEND;
            end
        end

        st_d.pend   = (st_q.pend || req.pend_set) && !st_d.enter;
        st_d.halted = st_d.enter || (st_q.halted && !go_cmd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/halt_src_arb.sv
module halt_src_arb
    import halt_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_in_exc,
    input  logic       bkpt_trig,
    input  logic       halt_op,
    input  logic       bgnd_cmd,
    input  logic       go_cmd,
    input  logic       insn_bound,
    input  logic       sup_mode,
    input  logic       dbg_en,
    input  logic       flash_secure,
    input  logic       cpu_stopped,
    input  logic       user_halt_en,
    input  logic       rst_dis_priv,
    input  logic       rst_dis_illegal,
    output logic       halted,
    output logic       halt_enter,
    output logic [1:0] halt_cause,
    output logic       pend_halt,
    output logic [1:0] exc_kind,
    output logic       reset_req,
    output logic       cmd_err
);
    src_req_t   req;
    arb_state_t st_q;

    halt_src_decode i_decode (
        .halted_q        (st_q.halted),
        .fault_in_exc    (fault_in_exc),
        .bkpt_trig       (bkpt_trig),
        .halt_op         (halt_op),
        .bgnd_cmd        (bgnd_cmd),
        .sup_mode        (sup_mode),
        .dbg_en          (dbg_en),
        .flash_secure    (flash_secure),
        .cpu_stopped     (cpu_stopped),
        .user_halt_en    (user_halt_en),
        .rst_dis_priv    (rst_dis_priv),
        .rst_dis_illegal (rst_dis_illegal),
        .req             (req)
    );

    halt_src_core i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .go_cmd     (go_cmd),
        .insn_bound (insn_bound),
        .st_q       (st_q)
    );

    assign halted     = st_q.halted;
    assign halt_enter = st_q.enter;
    assign halt_cause = st_q.cause;
    assign pend_halt  = st_q.pend;
    assign exc_kind   = st_q.exc;
    assign reset_req  = st_q.reset_req;
    assign cmd_err    = st_q.cmd_err;
endmodule

// File: rtl/halt_src_arb_chk.sv
module halt_src_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fault_in_exc,
    input logic       bgnd_cmd,
    input logic       go_cmd,
    input logic       dbg_en,
    input logic       flash_secure,
    input logic       halted,
    input logic       halt_enter,
    input logic       pend_halt,
    input logic [1:0] exc_kind,
    input logic       reset_req,
    input logic       cmd_err
);
    assert_reset_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (!halt_enter && exc_kind == 2'd0));

    assert_halt_over_exc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |-> exc_kind == 2'd0);

    assert_enter_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |-> halted);

    assert_pend_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_enter |-> !pend_halt);

    assert_go_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && go_cmd) |=> !halted);

    assert_halted_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !go_cmd) |=> halted);

    assert_cmd_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bgnd_cmd && (!dbg_en || flash_secure)) |=> cmd_err);

    assert_fof_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_in_exc && !halted && !dbg_en) |=> reset_req);
endmodule

bind halt_src_arb halt_src_arb_chk i_chk (.*);

// File: tb/test_halt_src_arb.sv
module test_halt_src_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    typedef struct packed {
        logic fault, bkpt, hop, bgnd, go, bound, sup, dbg, sec, stop, uhe, rdp, rdi;
    } in_t;

    in_t x = '0;
    logic halted, halt_enter, pend_halt, reset_req, cmd_err;
    logic [1:0] halt_cause, exc_kind;

    halt_src_arb i_halt_src_arb (
        .clk(clk), .rst_n(rst_n),
        .fault_in_exc(x.fault), .bkpt_trig(x.bkpt), .halt_op(x.hop),
        .bgnd_cmd(x.bgnd), .go_cmd(x.go), .insn_bound(x.bound),
        .sup_mode(x.sup), .dbg_en(x.dbg), .flash_secure(x.sec),
        .cpu_stopped(x.stop), .user_halt_en(x.uhe),
        .rst_dis_priv(x.rdp), .rst_dis_illegal(x.rdi),
        .halted(halted), .halt_enter(halt_enter), .halt_cause(halt_cause),
        .pend_halt(pend_halt), .exc_kind(exc_kind), .reset_req(reset_req),
        .cmd_err(cmd_err)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // expected-state model
    logic m_halted = 0, m_enter = 0, m_pend = 0, m_rst = 0, m_err = 0;
    logic [1:0] m_cause = 0, m_exc = 0;

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(in_t v);
        logic live, fof, hop, okbg, hok, prv, ill, rst, imm, tp, ent;
        logic [1:0] cause, exc;
        live = !m_halted;
        fof  = live && v.fault;
        hop  = live && v.hop;
        okbg = v.bgnd && v.dbg && !v.sec;
        hok  = hop && v.dbg && (v.sup || v.uhe);
        prv  = hop && v.dbg && !v.sup && !v.uhe;
        ill  = hop && !v.dbg;
        rst  = (fof && !v.dbg) || (prv && !v.rdp) || (ill && !v.rdi);
        imm  = (fof && v.dbg) || hok || (live && okbg && v.stop);
        cause = (fof && v.dbg) ? 2'd0 : hok ? 2'd1 : 2'd3;
        exc  = (prv && v.rdp) ? 2'd1 : (ill && v.rdi) ? 2'd2 : 2'd0;
        tp   = m_pend && v.bound && exc == 2'd0;
        ent  = 1'b0;
        m_exc = 2'd0;
        if (!rst) begin
            if (imm) begin ent = live; m_cause = cause; end
            else if (exc != 2'd0) m_exc = exc;
            else if (tp && live) begin ent = 1'b1; m_cause = 2'd2; end
        end
        m_pend   = (m_pend || (live && v.bkpt) || (live && okbg && !v.stop)) && !ent;
        m_halted = ent || (m_halted && !v.go);
        m_enter  = ent;
        m_rst    = rst;
        m_err    = v.bgnd && (!v.dbg || v.sec);
    endtask

    task automatic compare();
        chk("R11 R3 R8 halt_enter", {1'b0, halt_enter}, {1'b0, m_enter});
        chk("R9 halted", {1'b0, halted}, {1'b0, m_halted});
        chk("R7 pend_halt", {1'b0, pend_halt}, {1'b0, m_pend});
        chk("R2 R8 halt_cause", halt_cause, m_cause);
        chk("R4 R5 R10 exc_kind", exc_kind, m_exc);
        chk("R2 R4 R5 reset_req", {1'b0, reset_req}, {1'b0, m_rst});
        chk("R6 cmd_err", {1'b0, cmd_err}, {1'b0, m_err});
    endtask

    // one cycle: drive at negedge, check at the following negedge
    task automatic cyc(in_t v);
        x = v;
        model_step(v);
        @(negedge clk);
        compare();
    endtask

    function automatic in_t base();
        in_t v = '0;
        v.dbg = 1; v.sup = 1;
        return v;
    endfunction

    initial begin
        in_t v;
        void'($urandom(32'd2024));
        x = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {halted, halt_enter}, 2'b00);
        chk("R1 reset exc", exc_kind, 2'd0);
        chk("R1 reset pend/rst", {pend_halt, reset_req}, 2'b00);

        // R3 halt op in supervisor, then GO
        v = base(); v.hop = 1; cyc(v);
        v = base(); cyc(v);
        // R9 halt op while halted ignored
        v = base(); v.hop = 1; v.sup = 0; cyc(v);
        v = base(); v.go = 1; cyc(v);
        // R9 go while running ignored
        v = base(); v.go = 1; cyc(v);
        // R4 privilege reset, then exception
        v = base(); v.hop = 1; v.sup = 0; cyc(v);
        v = base(); v.hop = 1; v.sup = 0; v.rdp = 1; cyc(v);
        // R5 illegal reset and exception
        v = base(); v.dbg = 0; v.hop = 1; cyc(v);
        v = base(); v.dbg = 0; v.hop = 1; v.rdi = 1; cyc(v);
        // R2 fault-on-fault both ways
        v = base(); v.dbg = 0; v.fault = 1; cyc(v);
        v = base(); v.fault = 1; cyc(v);
        v = base(); v.go = 1; cyc(v);
        // R7 breakpoint pending, no boundary, then boundary
        v = base(); v.bkpt = 1; cyc(v);
        v = base(); cyc(v);
        // R10 exception collides with boundary: pending kept
        v = base(); v.bound = 1; v.hop = 1; v.sup = 0; v.rdp = 1; cyc(v);
        v = base(); v.bound = 1; cyc(v);
        v = base(); v.go = 1; cyc(v);
        // R6 background while secure
        v = base(); v.bgnd = 1; v.sec = 1; cyc(v);
        // R8 background while stopped
        v = base(); v.bgnd = 1; v.stop = 1; cyc(v);
        v = base(); v.go = 1; cyc(v);
        // R7 background while running then boundary
        v = base(); v.bgnd = 1; cyc(v);
        v = base(); v.bound = 1; cyc(v);
        v = base(); v.go = 1; cyc(v);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            v = '0;
            v.fault = ($urandom % 20) == 0;
            v.bkpt  = ($urandom % 10) == 0;
            v.hop   = ($urandom % 6) == 0;
            v.bgnd  = ($urandom % 8) == 0;
            v.go    = ($urandom % 5) == 0;
            v.bound = ($urandom % 3) == 0;
            v.sup   = $urandom % 2;
            v.dbg   = ($urandom % 4) != 0;
            v.sec   = ($urandom % 5) == 0;
            v.stop  = ($urandom % 4) == 0;
            v.uhe   = $urandom % 2;
            v.rdp   = $urandom % 2;
            v.rdi   = $urandom % 2;
            cyc(v);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule